// File: doc/BRIEF.md
# Result Latency Scoreboard

The block tracks, for every architectural register, how many cycles remain before the result of an in-flight producer can be consumed. When the issue port writes a destination register, the slot for that register loads a wait count taken from the class of the producing operation. Each slot then counts down by one per cycle until it reaches zero.

In every cycle the issue stage presents the two source registers and the class of a candidate consumer. The block answers combinationally whether both sources can be read. Consumers that read their upper half late get a one-cycle shorter wait. This applies to 128-bit vector move-type and add-type consumers fed by a 128-bit vector move-type or add-type producer.

Register zero is hardwired ready. Operations without a register result leave the slots untouched.

Top module: `latency_scoreboard`

## Requirements
- R1: While reset is asserted, and after it is released with no issue, every slot is idle and `rdy_o` is 1 for any pair of sources.
- R2: Class codes (5 bits) and latencies in cycles are:
  - integer: 0 ALU/shift 1, 1 shifted or extended arithmetic 2, 2 conditional select 2, 3 integer multiply 4, 4 integer divide 22, 5 scalar load 3, 6 store (no result);
  - floating point: 7 FP add 4, 8 FP constant 1, 9 FP move/min/max/select/abs/neg 2, 10 GPR-FP transfer 2, 11 FP multiply or multiply-add 6, 12 FP divide single 12, 13 FP divide double 22, 14 FP square root single 17, 15 FP square root double 28, 16 round to integral 4, 17 conversion 6, 18 FP/vector load 4;
  - vector: 19 vector move/logic/compare 2, 20 the 128-bit form of code 19 3, 21 vector add-type 4, 22 the 128-bit form of code 21 5;
  - codes 23 to 31 have no result.
- R3: A producer of latency L issued to register d in cycle t makes a consumer of d see `rdy_o`=0 in cycles t+1 to t+L-1 and `rdy_o`=1 from cycle t+L, when no bypass applies.
- R4: A slot decrements once per cycle and stays at zero, so a register stays ready once ready until it is written again.
- R5: A new issue to a register with a pending result replaces its wait with the new class's latency, whether the new latency is shorter or longer.
- R6: An issue with a class that has no result (code 6 or 23 to 31), or an issue to register 0, changes no slot.
- R7: Register 0 is always ready as a source.
- R8: When the producer class is 20 or 22 and the consumer class is 20 or 22, the wait is one cycle shorter: 2 after class 20 and 4 after class 22. Any other pairing, for example a class 21 producer or a class 21 consumer, uses the full latency.
- R9: `rdy_o` is the AND of the two sources' readiness. The answer reflects slot state before any issue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue of a producer this cycle |
| iss_rd_i | input | 5 | Destination register of the producer |
| iss_class_i | input | 5 | Operation class code of the producer (R2) |
| chk_rs1_i | input | 5 | First source register of the consumer |
| chk_rs2_i | input | 5 | Second source register of the consumer |
| chk_class_i | input | 5 | Operation class code of the consumer |
| rdy_o | output | 1 | Both sources can be consumed this cycle |

## Verification
An issue is captured at the rising edge that ends its issue cycle, and `rdy_o` is a combinational function of the slot registers. A producer of latency L issued in cycle t therefore turns `rdy_o` on for its register exactly in cycle t+L, or in cycle t+L-1 when the bypass pairing applies. The bench drives each issue for one clock period starting at a falling edge. It then samples `rdy_o` one nanosecond after each later falling edge. For every class and pairing it checks the last busy cycle and the first ready cycle against a latency table of its own. The same-cycle check of R9 samples before the capturing edge.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned CLS_W = 5;
  localparam int unsigned LAT_W = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU      = 5'd0,
    CLS_ALU_SHX  = 5'd1,
    CLS_CSEL     = 5'd2,
    CLS_IMUL     = 5'd3,
    CLS_IDIV     = 5'd4,
    CLS_LOAD     = 5'd5,
    CLS_STORE    = 5'd6,
    CLS_FADD     = 5'd7,
    CLS_FCONST   = 5'd8,
    CLS_FMOV     = 5'd9,
    CLS_FGPR     = 5'd10,
    CLS_FMUL     = 5'd11,
    CLS_FDIV_S   = 5'd12,
    CLS_FDIV_D   = 5'd13,
    CLS_FSQRT_S  = 5'd14,
    CLS_FSQRT_D  = 5'd15,
    CLS_FRINT    = 5'd16,
    CLS_FCVT     = 5'd17,
    CLS_VLOAD    = 5'd18,
    CLS_VMOV     = 5'd19,
    CLS_VMOV_Q   = 5'd20,
    CLS_VADD     = 5'd21,
    CLS_VADD_Q   = 5'd22
  } op_class_e;

  typedef struct packed {
    logic             has_dst;
    logic             late_hi;  // 128-bit producer eligible for the short path
    logic [LAT_W-1:0] lat;
  } lat_info_t;
endpackage

// File: rtl/sb_class_decode.sv
module sb_class_decode
  import sb_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output lat_info_t        info_o
);
  op_class_e cls;
  assign cls = op_class_e'(cls_i);

  always_comb begin
    info_o = '{has_dst: 1'b1, late_hi: 1'b0, lat: LAT_W'(1)};
    unique case (cls)
      CLS_ALU:     info_o.lat = LAT_W'(1);
      CLS_ALU_SHX: info_o.lat = LAT_W'(2);
      CLS_CSEL:    info_o.lat = LAT_W'(2);
      CLS_IMUL:    info_o.lat = LAT_W'(4);
      CLS_IDIV:    info_o.lat = LAT_W'(22);
      CLS_LOAD:    info_o.lat = LAT_W'(3);
      CLS_FADD:    info_o.lat = LAT_W'(4);
      CLS_FCONST:  info_o.lat = LAT_W'(1);
      CLS_FMOV:    info_o.lat = LAT_W'(2);
      CLS_FGPR:    info_o.lat = LAT_W'(2);
      CLS_FMUL:    info_o.lat = LAT_W'(6);
      CLS_FDIV_S:  info_o.lat = LAT_W'(12);
      CLS_FDIV_D:  info_o.lat = LAT_W'(22);
      CLS_FSQRT_S: info_o.lat = LAT_W'(17);
      CLS_FSQRT_D: info_o.lat = LAT_W'(28);
      CLS_FRINT:   info_o.lat = LAT_W'(4);
      CLS_FCVT:    info_o.lat = LAT_W'(6);
      CLS_VLOAD:   info_o.lat = LAT_W'(4);
      CLS_VMOV:    info_o.lat = LAT_W'(2);
      CLS_VMOV_Q:  begin info_o.lat = LAT_W'(3); info_o.late_hi = 1'b1; end
      CLS_VADD:    info_o.lat = LAT_W'(4);
      CLS_VADD_Q:  begin info_o.lat = LAT_W'(5); info_o.late_hi = 1'b1; end
      default:     info_o.has_dst = 1'b0;  // stores and unassigned codes
    endcase
  end
endmodule

// File: rtl/sb_cnt_slot.sv
module sb_cnt_slot #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             load_hi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             late_hi_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      hi_q  <= load_hi_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign late_hi_o = hi_q;
endmodule

// File: rtl/sb_src_check.sv
module sb_src_check #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [IDX_W-1:0]                  src_i,
  input  logic [NUM_REGS-1:0][CNT_W-1:0]    cnt_i,
  input  logic [NUM_REGS-1:0]               late_hi_i,
  input  logic                              cons_hi_i,
  output logic                              ready_o
);
  logic [CNT_W-1:0] cnt_sel;
  logic             hi_sel;

  assign cnt_sel = cnt_i[src_i];
  assign hi_sel  = late_hi_i[src_i];

  // short path: one remaining cycle is hidden by the late upper-half read
  assign ready_o = (src_i == '0) || (cnt_sel == '0) ||
                   (cons_hi_i && hi_sel && (cnt_sel == CNT_W'(1)));
endmodule

// File: rtl/latency_scoreboard.sv
module latency_scoreboard
  import sb_pkg::*;
#(
  parameter  int unsigned NUM_REGS = 32,
  parameter  int unsigned CNT_W    = 5,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iss_valid_i,
  input  logic [IDX_W-1:0] iss_rd_i,
  input  logic [CLS_W-1:0] iss_class_i,
  input  logic [IDX_W-1:0] chk_rs1_i,
  input  logic [IDX_W-1:0] chk_rs2_i,
  input  logic [CLS_W-1:0] chk_class_i,
  output logic             rdy_o
);
  lat_info_t                     iss_info;
  logic [CNT_W-1:0]              load_val;
  logic [NUM_REGS-1:0]           wr_en;
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_REGS-1:0]           late_hi_q;
  logic                          cons_hi;
  logic                          rs1_ok;
  logic                          rs2_ok;

  sb_class_decode u_dec (
    .cls_i  (iss_class_i),
    .info_o (iss_info)
  );

  // counter holds cycles left after the capturing edge
  assign load_val = CNT_W'(iss_info.lat) - CNT_W'(1);

  assign cons_hi = (chk_class_i == CLS_VMOV_Q) || (chk_class_i == CLS_VADD_Q);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    if (g == 0) begin : g_zero
      assign wr_en[g]     = 1'b0;
      assign cnt_q[g]     = '0;
      assign late_hi_q[g] = 1'b0;
    end else begin : g_reg
      assign wr_en[g] = iss_valid_i && iss_info.has_dst && (iss_rd_i == IDX_W'(g));
      sb_cnt_slot #(.CNT_W(CNT_W)) u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (wr_en[g]),
        .load_val_i (load_val),
        .load_hi_i  (iss_info.late_hi),
        .cnt_o      (cnt_q[g]),
        .late_hi_o  (late_hi_q[g])
      );
    end
  end

  sb_src_check #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk1 (
    .src_i     (chk_rs1_i),
    .cnt_i     (cnt_q),
    .late_hi_i (late_hi_q),
    .cons_hi_i (cons_hi),
    .ready_o   (rs1_ok)
  );

  sb_src_check #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk2 (
    .src_i     (chk_rs2_i),
    .cnt_i     (cnt_q),
    .late_hi_i (late_hi_q),
    .cons_hi_i (cons_hi),
    .ready_o   (rs2_ok)
  );

  assign rdy_o = rs1_ok && rs2_ok;
endmodule

// File: rtl/latency_scoreboard_chk.sv
module latency_scoreboard_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned IDX_W    = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [IDX_W-1:0]               chk_rs1_i,
  input logic [IDX_W-1:0]               chk_rs2_i,
  input logic                           rdy_o,
  input logic [NUM_REGS-1:0]            wr_en_i,
  input logic [CNT_W-1:0]               load_val_i,
  input logic [NUM_REGS-1:0][CNT_W-1:0] cnt_i
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i[g] && cnt_i[g] != '0) |=> (cnt_i[g] == $past(cnt_i[g]) - 1'b1));

    p_hold_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i[g] && cnt_i[g] == '0) |=> (cnt_i[g] == '0));

    p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[g] |=> (cnt_i[g] == $past(load_val_i)));
  end

  p_r0_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i[0] == '0);

  p_zero_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_rs1_i == '0 && chk_rs2_i == '0) |-> rdy_o);

  // the short path hides at most one cycle
  p_busy_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i[chk_rs1_i] > CNT_W'(1)) |-> !rdy_o);

  p_busy_blocks2_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i[chk_rs2_i] > CNT_W'(1)) |-> !rdy_o);
endmodule

bind latency_scoreboard latency_scoreboard_chk #(
  .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) i_sb_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chk_rs1_i  (chk_rs1_i),
  .chk_rs2_i  (chk_rs2_i),
  .rdy_o      (rdy_o),
  .wr_en_i    (wr_en),
  .load_val_i (load_val),
  .cnt_i      (cnt_q)
);

// File: tb/test_latency_scoreboard.sv
`timescale 1ns/1ps
module test_latency_scoreboard;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       iss_valid_i = 1'b0;
  logic [4:0] iss_rd_i = '0;
  logic [4:0] iss_class_i = '0;
  logic [4:0] chk_rs1_i = '0;
  logic [4:0] chk_rs2_i = '0;
  logic [4:0] chk_class_i = '0;
  logic       rdy_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  latency_scoreboard i_latency_scoreboard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .iss_valid_i (iss_valid_i),
    .iss_rd_i    (iss_rd_i),
    .iss_class_i (iss_class_i),
    .chk_rs1_i   (chk_rs1_i),
    .chk_rs2_i   (chk_rs2_i),
    .chk_class_i (chk_class_i),
    .rdy_o       (rdy_o)
  );

  // latency table per R2, independent of the design
  function automatic int ref_lat(int c);
    case (c)
      0: return 1;   1: return 2;   2: return 2;   3: return 4;
      4: return 22;  5: return 3;   7: return 4;   8: return 1;
      9: return 2;   10: return 2;  11: return 6;  12: return 12;
      13: return 22; 14: return 17; 15: return 28; 16: return 4;
      17: return 6;  18: return 4;  19: return 2;  20: return 3;
      21: return 4;  22: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_wait(int p, int c);
    if ((p == 20 || p == 22) && (c == 20 || c == 22)) return ref_lat(p) - 1; // R8
    return ref_lat(p);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rdy_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic probe(string req, logic [4:0] rs1, logic [4:0] rs2, logic [4:0] cls, logic exp);
    chk_rs1_i = rs1; chk_rs2_i = rs2; chk_class_i = cls;
    #1 check(req, rdy_o, exp);
  endtask

  // starts at a falling edge, returns at the falling edge after capture
  task automatic drive_issue(logic [4:0] rd, logic [4:0] cls);
    iss_valid_i = 1'b1; iss_rd_i = rd; iss_class_i = cls;
    @(negedge clk_i);
    iss_valid_i = 1'b0;
  endtask

  task automatic run_profile(string req, logic [4:0] rd, int prod, int cons, int w);
    drive_issue(rd, 5'(prod));
    for (int k = 1; k <= w + 1; k++) begin
      probe(req, rd, 5'd0, 5'(cons), k >= w);
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    probe("R1", 5'd5, 5'd17, 5'd0, 1'b1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    probe("R1", 5'd31, 5'd1, 5'd22, 1'b1);
    probe("R7", 5'd0, 5'd0, 5'd0, 1'b1);
  endtask

  task automatic t_class_sweep(); // R2 R3 R4
    for (int c = 0; c <= 22; c++) begin
      if (c != 6) run_profile("R3", 5'd5, c, 0, ref_lat(c));
    end
  endtask

  task automatic t_overwrite(); // R5
    drive_issue(5'd7, 5'd4);
    probe("R5", 5'd7, 5'd0, 5'd0, 1'b0);
    @(negedge clk_i);
    drive_issue(5'd7, 5'd0);
    probe("R5", 5'd7, 5'd0, 5'd0, 1'b1);
    drive_issue(5'd7, 5'd0);
    run_profile("R5", 5'd7, 15, 0, 28);
  endtask

  task automatic t_no_result(); // R6 R7
    drive_issue(5'd9, 5'd6);
    probe("R6", 5'd9, 5'd0, 5'd0, 1'b1);
    drive_issue(5'd9, 5'd31);
    probe("R6", 5'd9, 5'd0, 5'd0, 1'b1);
    drive_issue(5'd0, 5'd4);
    probe("R7", 5'd0, 5'd0, 5'd0, 1'b1);
    // a store landing on a pending register keeps the wait
    drive_issue(5'd9, 5'd11);
    drive_issue(5'd9, 5'd6);
    for (int k = 2; k <= 6; k++) begin
      probe("R6", 5'd9, 5'd0, 5'd0, k >= 6);
      @(negedge clk_i);
    end
  endtask

  task automatic t_bypass(); // R8
    run_profile("R8", 5'd12, 20, 20, ref_wait(20, 20));
    run_profile("R8", 5'd12, 20, 22, ref_wait(20, 22));
    run_profile("R8", 5'd12, 20, 21, ref_wait(20, 21));
    run_profile("R8", 5'd12, 22, 20, ref_wait(22, 20));
    run_profile("R8", 5'd12, 22, 22, ref_wait(22, 22));
    run_profile("R8", 5'd12, 21, 22, ref_wait(21, 22));
    run_profile("R8", 5'd12, 19, 20, ref_wait(19, 20));
  endtask

  task automatic t_dual(); // R9
    iss_valid_i = 1'b1; iss_rd_i = 5'd3; iss_class_i = 5'd4;
    probe("R9", 5'd3, 5'd0, 5'd0, 1'b1);
    @(negedge clk_i);
    iss_valid_i = 1'b0;
    probe("R9", 5'd3, 5'd0, 5'd0, 1'b0);
    probe("R9", 5'd0, 5'd3, 5'd0, 1'b0);
    probe("R9", 5'd4, 5'd3, 5'd0, 1'b0);
    probe("R9", 5'd8, 5'd4, 5'd0, 1'b1);
    repeat (20) @(negedge clk_i);
    probe("R9", 5'd4, 5'd3, 5'd0, 1'b0);
    @(negedge clk_i);
    probe("R9", 5'd4, 5'd3, 5'd0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_class_sweep();
    t_overwrite();
    t_no_result();
    t_bypass();
    t_dual();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule